// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a bus target for a two-wire serial bus. It lets an external bus master read and write a bank of sixteen 8-bit configuration registers. Surrounding logic sees the bank on a flat parallel port. The wires SCL and SDA are oversampled by the system clock through short synchronizer chains. START and STOP conditions are found by comparing consecutive samples. The block never drives SDA high: it only asserts an active-high pull-low enable, which the pad turns into an open-drain output.

A write transfer starts with an address byte. The first data byte after it loads the register pointer; the low four bits are used. Each later byte is stored at the pointer, and the pointer then steps forward, wrapping from 15 to 0. To do a random read, the master writes only the pointer byte, issues a repeated START and sends the address again with the read bit set. Reads begin at the current pointer and advance with the same wrap.

The target answers one fixed address, plus a second address pattern whose three low bits are ignored. The register bank has no streaming handshake: its contents are plain levels that are always valid. The bus side has no back-pressure, because the target never stretches the clock. Every byte it acknowledges is handled within the SCL low phase that follows.

Top module: `i2c_cfg_target`

## Requirements
- R1: A falling SDA while SCL is high (START) begins reception of a new address byte from any state. This includes the middle of a byte, where the partial byte is dropped.
- R2: A rising SDA while SCL is high (STOP) returns the block to idle with `sda_pull` low. Nothing is driven until the next START.
- R3: Address byte bits [7:1] equal to 1011100 are acknowledged for both values of bit 0, the R/W bit (0 = write, 1 = read). The acknowledge is `sda_pull` high during the ninth clock.
- R4: Address bits [7:1] of the form 1010xxx are acknowledged for all eight values of xxx. Such transfers reach the same registers.
- R5: Every other address, including the general call address 0000000, gets no acknowledge. The data bytes that follow it in the same transfer change no register.
- R6: In a write transfer, the low four bits of the first data byte set the pointer, and the upper four bits are ignored. Each later byte is written to register[pointer], acknowledged, and followed by a pointer increment. Register k appears on `reg_bank[8k+7:8k]`.
- R7: The pointer wraps from 15 to 0, so a longer write overwrites registers 0, 1, … in order.
- R8: In a read transfer, the bytes come out MSB first, starting at the current pointer. The pointer increments after each byte and wraps from 15 to 0. The pointer survives between transfers.
- R9: When the master leaves SDA high on the acknowledge clock after a read byte, the block releases SDA. It then drives nothing until a START or STOP.
- R10: Apart from the release forced by START or STOP, `sda_pull` changes only while SCL is low.
- R11: After reset, all registers and the pointer are zero and `sda_pull` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock wire as seen at the pad |
| sda_in | input | 1 | Bus data wire as seen at the pad |
| sda_pull | output | 1 | High pulls SDA low; low leaves it released |
| reg_bank | output | 128 | All registers, register k at bits [8k+7:8k] |

## Verification
The bound checker covers behaviours that must hold on every cycle. START always lands in address reception and STOP always lands in idle, both with SDA released. The pull-low enable moves only during SCL low. Idle never drives, and the pointer wraps from 15 to 0 on every write or read advance. The remaining behaviours only show up in bench scenarios. These are which addresses get acknowledged (the full 128-address sweep), that a rejected transfer leaves the bank untouched, and the data values landing in and coming out of the right registers. They also include the dropped partial byte before a repeated START and the silence after a master's not-acknowledge.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  // SDA edges only count as conditions when SCL is high on both samples
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int              AW          = 7,
  parameter logic [AW-1:0]   FIXED_ADDR  = 7'h5C,
  parameter logic [AW-1:0]   ALT_ADDR    = 7'h50,
  parameter int              ALT_DC_BITS = 3
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  localparam logic [AW-1:0] ALT_MASK = ~((AW'(1) << ALT_DC_BITS) - AW'(1));

  logic fixed_hit;
  logic alt_hit;

  assign fixed_hit = (addr == FIXED_ADDR);

  generate
    if (ALT_DC_BITS == 0) begin : g_alt_exact
      assign alt_hit = (addr == ALT_ADDR);
    end else begin : g_alt_masked
      assign alt_hit = ((addr & ALT_MASK) == (ALT_ADDR & ALT_MASK));
    end
  endgenerate

  assign hit = fixed_hit | alt_hit;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NREGS = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [PW-1:0]     ptr_val,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_adv,
  output logic [DW-1:0]     rd_data,
  output logic [PW-1:0]     ptr,
  output logic [NREGS*DW-1:0] bank
);

  localparam logic [PW-1:0] LAST = PW'(NREGS - 1);

  logic [DW-1:0] regs [NREGS];
  logic [PW-1:0] ptr_next;

  assign ptr_next = (ptr == LAST) ? '0 : ptr + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_load) begin
      ptr <= ptr_val;
    end else if (wr_en || rd_adv) begin
      ptr <= ptr_next;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NREGS; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs[k] <= '0;
        end else if (wr_en && (ptr == PW'(k))) begin
          regs[k] <= wr_data;
        end
      end
      assign bank[k*DW +: DW] = regs[k];
    end
  endgenerate

  assign rd_data = regs[ptr];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_cfg_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PW  = 4,
  localparam int AW = DW - 1,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          addr_hit,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic          ptr_load,
  output logic [PW-1:0] ptr_val,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          rd_adv,
  output logic          sda_pull,
  output tgt_state_e    state
);

  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [DW-1:0] shreg;
  logic [DW-1:0] txreg;
  logic [CW-1:0] cnt;
  logic          rw_bit;
  logic          first_byte;
  logic          master_ack;

  assign addr    = shreg[DW-1:1];
  assign wr_data = shreg;
  assign ptr_val = shreg[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      txreg      <= '0;
      cnt        <= '0;
      rw_bit     <= 1'b0;
      first_byte <= 1'b0;
      master_ack <= 1'b0;
      sda_pull   <= 1'b0;
      ptr_load   <= 1'b0;
      wr_en      <= 1'b0;
      rd_adv     <= 1'b0;
    end else begin
      ptr_load <= 1'b0;
      wr_en    <= 1'b0;
      rd_adv   <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[DW-2:0], sda_lvl};
              cnt   <= cnt + CW'(1);
            end else if (scl_fall && cnt == FULL) begin
              rw_bit <= shreg[0];
              if (addr_hit) begin
                state    <= ST_ADDR_ACK;
                sda_pull <= 1'b1;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_bit) begin
                txreg    <= rd_data;
                sda_pull <= ~rd_data[DW-1];
                state    <= ST_RD;
              end else begin
                sda_pull   <= 1'b0;
                first_byte <= 1'b1;
                state      <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[DW-2:0], sda_lvl};
              cnt   <= cnt + CW'(1);
            end else if (scl_fall && cnt == FULL) begin
              if (first_byte) begin
                ptr_load   <= 1'b1;
                first_byte <= 1'b0;
              end else begin
                wr_en <= 1'b1;
              end
              sda_pull <= 1'b1;
              state    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              state    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_pull   <= 1'b0;
                rd_adv     <= 1'b1;
                master_ack <= 1'b0;
                state      <= ST_RD_ACK;
              end else begin
                txreg    <= {txreg[DW-2:0], 1'b0};
                sda_pull <= ~txreg[DW-2];
                cnt      <= cnt + CW'(1);
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (master_ack) begin
                txreg    <= rd_data;
                sda_pull <= ~rd_data[DW-1];
                cnt      <= '0;
                state    <= ST_RD;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_HOLD: ;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int            NREGS       = 16,
  parameter int            DW          = 8,
  parameter logic [DW-2:0] FIXED_ADDR  = 7'h5C,
  parameter logic [DW-2:0] ALT_ADDR    = 7'h50,
  parameter int            ALT_DC_BITS = 3,
  parameter int            SYNC_STAGES = 2,
  localparam int           PW          = $clog2(NREGS),
  localparam int           AW          = DW - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_pull,
  output logic [NREGS*DW-1:0] reg_bank
);

  logic          scl_lvl;
  logic          sda_lvl;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic [AW-1:0] addr;
  logic          addr_hit;
  logic          ptr_load;
  logic [PW-1:0] ptr_val;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          rd_adv;
  logic [DW-1:0] rd_data;
  logic [PW-1:0] ptr;
  tgt_state_e    state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_addr_match #(
    .AW          (AW),
    .FIXED_ADDR  (FIXED_ADDR),
    .ALT_ADDR    (ALT_ADDR),
    .ALT_DC_BITS (ALT_DC_BITS)
  ) u_match (
    .addr (addr),
    .hit  (addr_hit)
  );

  i2c_target_fsm #(.DW(DW), .PW(PW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_hit  (addr_hit),
    .rd_data   (rd_data),
    .addr      (addr),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_adv    (rd_adv),
    .sda_pull  (sda_pull),
    .state     (state)
  );

  i2c_reg_bank #(.NREGS(NREGS), .DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (ptr_load),
    .ptr_val  (ptr_val),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_adv   (rd_adv),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .bank     (reg_bank)
  );

endmodule

// File: rtl/i2c_cfg_checker.sv
module i2c_cfg_checker
  import i2c_cfg_pkg::*;
#(
  parameter int  NREGS = 16,
  localparam int PW    = $clog2(NREGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_pull,
  input logic          wr_en,
  input logic          rd_adv,
  input logic [PW-1:0] ptr,
  input tgt_state_e    state
);

  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && !sda_pull));

  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_pull));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull);

  assert_pull_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_adv) && ptr == PW'(NREGS - 1)) |=> (ptr == '0));

endmodule

bind i2c_cfg_target i2c_cfg_checker #(.NREGS(NREGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_pull  (sda_pull),
  .wr_en     (wr_en),
  .rd_adv    (rd_adv),
  .ptr       (ptr),
  .state     (state)
);

// File: tb/sim_i2c_cfg_target.sv
module sim_i2c_cfg_target;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [NR*8-1:0] reg_bank;
  logic sda_line;

  int tests = 0;
  int fails = 0;
  int viol = 0;
  bit done = 1'b0;
  logic [7:0] expr [NR];
  int exp_ptr = 0;

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_target u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_m),
    .sda_in   (sda_line),
    .sda_pull (sda_pull),
    .reg_bank (reg_bank)
  );

  // R10 monitor: pull enable may only move while SCL is low at the pad
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_pull !== prev_pull && scl_m) viol++;
    prev_pull <= sda_pull;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bit(input bit b);
    wq(1); sda_m = b; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    acked = (sda_line == 1'b0);
    wq(1); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
      b[i] = sda_line;
      wq(1); scl_m = 1'b0;
    end
    wq(1); sda_m = ~mack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0;
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < NR; k++)
      check(reg_bank[k*8 +: 8] == expr[k], req, $sformatf("reg%0d", k),
            reg_bank[k*8 +: 8], expr[k]);
  endtask

  initial begin
    repeat (1000 * 190) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rb;
    for (int k = 0; k < NR; k++) expr[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    check(reg_bank == '0, "R11", "bank after reset", 0, 0);
    check(sda_pull == 1'b0, "R11", "pull after reset", sda_pull, 0);

    // R3 R4 R5: full address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      logic [6:0] ad;
      bit hit;
      ad = 7'(a);
      hit = (ad == 7'h5C) || (ad[6:3] == 4'b1010);
      bus_start();
      send_byte({ad, 1'b0}, ak);
      if (ad == 7'h5C) check(ak == hit, "R3", "fixed addr ack", ak, hit);
      else if (ad[6:3] == 4'b1010) check(ak == hit, "R4", $sformatf("alt addr %0h ack", a), ak, hit);
      else begin
        check(ak == hit, "R5", $sformatf("addr %0h ack", a), ak, hit);
        send_byte(8'h00, ak);
        check(ak == 1'b0, "R5", "data ack after reject", ak, 0);
        send_byte(8'hA5, ak);
      end
      bus_stop();
      check(sda_pull == 1'b0, "R2", "pull after stop", sda_pull, 0);
    end
    check(reg_bank == '0, "R5", "bank untouched by rejected writes", 0, 0);

    // R6: sequential write of all registers from pointer 0
    bus_start();
    send_byte({7'h5C, 1'b0}, ak);
    send_byte(8'h00, ak);
    check(ak, "R6", "pointer byte ack", ak, 1);
    for (int i = 0; i < NR; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11) & 255);
      send_byte(v, ak);
      check(ak, "R6", "data byte ack", ak, 1);
      expr[i] = v;
    end
    bus_stop();
    exp_ptr = 0;
    check_bank("R6");

    // R7: wrap, pointer byte 0xFE uses low bits only (14)
    bus_start();
    send_byte({7'h5C, 1'b0}, ak);
    send_byte(8'hFE, ak);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v;
      v = 8'(8'hC0 + i);
      send_byte(v, ak);
      expr[(14 + i) % NR] = v;
    end
    bus_stop();
    exp_ptr = (14 + 4) % NR;
    check_bank("R7");

    // R8 R1 R9: random read through alternate address with repeated START
    bus_start();
    send_byte({7'h53, 1'b0}, ak);
    send_byte(8'h0D, ak);
    bus_rstart();
    send_byte({7'h53, 1'b1}, ak);
    check(ak, "R4", "alt addr read ack", ak, 1);
    for (int i = 0; i < 5; i++) begin
      recv_byte(i != 4, rb);
      check(rb == expr[(13 + i) % NR], "R8", $sformatf("read byte %0d", i),
            rb, expr[(13 + i) % NR]);
    end
    wq(2);
    check(sda_pull == 1'b0, "R9", "released after nack", sda_pull, 0);
    recv_byte(1'b0, rb);
    check(rb == 8'hFF, "R9", "no drive while waiting for stop", rb, 8'hFF);
    bus_stop();
    exp_ptr = (13 + 5) % NR;

    // R1: repeated START mid-byte drops the partial byte
    bus_start();
    send_byte({7'h5C, 1'b0}, ak);
    send_byte(8'h03, ak);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_rstart();
    send_byte({7'h5C, 1'b0}, ak);
    check(ak, "R1", "address after repeated start", ak, 1);
    send_byte(8'h05, ak);
    send_byte(8'h77, ak);
    bus_stop();
    expr[5] = 8'h77;
    exp_ptr = 6;
    check_bank("R1");

    // R3 R8: direct read from current pointer, across the wrap
    bus_start();
    send_byte({7'h5C, 1'b1}, ak);
    check(ak, "R3", "fixed addr read ack", ak, 1);
    for (int i = 0; i < 18; i++) begin
      recv_byte(i != 17, rb);
      check(rb == expr[(exp_ptr + i) % NR], "R8", $sformatf("seq read %0d", i),
            rb, expr[(exp_ptr + i) % NR]);
    end
    bus_stop();

    // R10: monitor result
    check(viol == 0, "R10", "pull changes with SCL high", viol, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule